// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencer

This block is the digital controller for a three-rail slot power switch that serves a removable card slot. It supervises an auxiliary 3.3 V rail and two main rails (3.3 V and 1.5 V). From the system state and the card-detect pins it decides which rail switches to close, and it drives a discharge path on each rail that is off. It also generates an active-low card reset with a timed release and an undelayed reference-clock enable. The power FETs, comparators, current limits and soft start are outside this block. It sees their results only as power-good, undervoltage and over-temperature flags.

Every input passes through a two-stage synchronizer before any logic uses it. The rail enables are registered once after the synchronizer. The card reset is released only after a qualifying condition has held for a parameterised number of clock cycles, chosen to fall in the 4 to 20 ms window. The reset is pulled low combinationally as soon as the synchronized condition fails, so it drops well under half a microsecond after the event.

Top module: `slot_pwr_seq`

## Requirements
- R1: A card is present when `pcie_det_n_i` or `usb_det_n_i` is low. With both detects high, `rail_sw_o` is 3'b000 whatever the other inputs are.
- R2: With a card present, `en_i`=1, `sys_active_i`=1, `hot_i`=0 and no undervoltage, `rail_sw_o` is 3'b111. Rail order is bit 0 auxiliary 3.3 V, bit 1 main 3.3 V, bit 2 main 1.5 V. Rail outputs follow an input change on the third rising clock edge.
- R3: With a card present, `en_i`=1 and `sys_active_i`=0, only the auxiliary rail is on (`rail_sw_o`=3'b001). Toggling `sys_active_i` while the card stays present changes only bits 1 and 2.
- R4: When `en_i` is 0, `rail_sw_o` is 3'b000 and `rail_dis_o` is 3'b111. This is also the state during and right after reset.
- R5: For every rail, `rail_dis_o` is the inverse of `rail_sw_o`.
- R6: When `hot_i` is 1, `rail_sw_o` is 3'b000.
- R7: When bit i of `uvlo_i` is 1, rail i is off and the other rails are unaffected. Bit positions follow the rail order of R2.
- R8: `card_rst_n_o` goes high exactly RST_DELAY_CYC+2 rising edges after the input change that completes the qualifying condition. That condition is `pgood_i`=3'b111, `pcie_det_n_i`=0, `host_rst_n_i`=1 and `en_i`=1.
- R9: `card_rst_n_o` is low no later than the second rising edge after any part of the qualifying condition fails.
- R10: If the qualifying condition fails during the release count, the count starts again from zero.
- R11: `refclk_en_o` is 1 exactly when `en_i`=1, `pcie_det_n_i`=0 and `pgood_i`=3'b111. It follows the inputs on the second rising edge, with no release delay.
- R12: A card detected only on `usb_det_n_i` powers the rails but leaves `card_rst_n_o` and `refclk_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Global enable |
| sys_active_i | input | 1 | 1 = system active, 0 = standby |
| pcie_det_n_i | input | 1 | Active-low detect of a PCIe-capable card |
| usb_det_n_i | input | 1 | Active-low detect of a USB-capable card |
| host_rst_n_i | input | 1 | Host reset request, active low |
| pgood_i | input | 3 | Per-rail power-good flags |
| uvlo_i | input | 3 | Per-rail input undervoltage flags |
| hot_i | input | 1 | Over-temperature flag |
| rail_sw_o | output | 3 | Per-rail switch enable |
| rail_dis_o | output | 3 | Per-rail discharge enable |
| card_rst_n_o | output | 1 | Delayed active-low card reset |
| refclk_en_o | output | 1 | Undelayed reference-clock enable |

## Verification
The bench builds the block with RST_DELAY_CYC set to 16 and the default two synchronizer stages. With that setting, the release boundary can be checked one cycle before and on the exact release edge. The restart case, in which a power-good drops partway through the count, and several release cycles in a row also fit in a short run. Production values in the millisecond range only change the counter width, so the same boundary arithmetic covers them.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;

    localparam int NUM_RAILS   = 3;
    localparam int RAIL_AUX    = 0;
    localparam int RAIL_M33    = 1;
    localparam int RAIL_M15    = 2;
    localparam int SYNC_DEPTH  = 2;

    typedef logic [NUM_RAILS-1:0] rail_vec_t;

    // Synchronized view of every control input
    typedef struct packed {
        logic      en;
        logic      sys_on;
        logic      pcie_det_n;
        logic      usb_det_n;
        logic      host_go;
        logic      hot;
        rail_vec_t uvlo;
        rail_vec_t pgood;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Safe value held by the synchronizers during reset: disabled, no card
    localparam ctl_t CTL_IDLE = '{
        en:         1'b0,
        sys_on:     1'b0,
        pcie_det_n: 1'b1,
        usb_det_n:  1'b1,
        host_go:    1'b0,
        hot:        1'b0,
        uvlo:       '0,
        pgood:      '0
    };

    function automatic logic card_present(ctl_t c);
        return !c.pcie_det_n || !c.usb_det_n;
    endfunction

    // Main rails additionally need the system to be active
    function automatic logic rail_allowed(ctl_t c, int idx);
        logic base;
        base = c.en && !c.hot && card_present(c) && !c.uvlo[idx];
        return base && ((idx == RAIL_AUX) || c.sys_on);
    endfunction

    function automatic logic reset_release_ok(ctl_t c);
        return (&c.pgood) && !c.pcie_det_n && c.host_go && c.en;
    endfunction

    function automatic logic refclk_ok(ctl_t c);
        return c.en && !c.pcie_det_n && (&c.pgood);
    endfunction

endpackage

// File: rtl/spw_sync.sv
module spw_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spw_rail_ctrl.sv
module spw_rail_ctrl
    import slot_pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ctl_t      ctl,
    output rail_vec_t sw_q
);

    rail_vec_t cmd;

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        assign cmd[r] = rail_allowed(ctl, r);
    end

    always_ff @(posedge clk) begin
        if (rst) sw_q <= '0;
        else     sw_q <= cmd;
    end

endmodule

// File: rtl/spw_rst_timer.sv
module spw_rst_timer #(
    parameter int DELAY_CYC = 600000
) (
    input  logic clk,
    input  logic rst,
    input  logic qual,
    output logic done
);

    localparam int            CW    = $clog2(DELAY_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYC);

    logic [CW-1:0] cnt;

    // Any break in the condition restarts the count from zero
    always_ff @(posedge clk) begin
        if (rst || !qual)      cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIMIT);

endmodule

// File: rtl/slot_pwr_seq.sv
module slot_pwr_seq
    import slot_pwr_pkg::*;
#(
    parameter int RST_DELAY_CYC = 600000,
    parameter int SYNC_STAGES   = SYNC_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       sys_active_i,
    input  logic       pcie_det_n_i,
    input  logic       usb_det_n_i,
    input  logic       host_rst_n_i,
    input  logic [2:0] pgood_i,
    input  logic [2:0] uvlo_i,
    input  logic       hot_i,
    output logic [2:0] rail_sw_o,
    output logic [2:0] rail_dis_o,
    output logic       card_rst_n_o,
    output logic       refclk_en_o
);

    ctl_t              ctl_raw;
    logic [CTL_W-1:0]  ctl_sync;
    ctl_t              ctl_s;
    rail_vec_t         sw_q;
    logic              qual;
    logic              rel_done;

    assign ctl_raw = '{
        en:         en_i,
        sys_on:     sys_active_i,
        pcie_det_n: pcie_det_n_i,
        usb_det_n:  usb_det_n_i,
        host_go:    host_rst_n_i,
        hot:        hot_i,
        uvlo:       uvlo_i,
        pgood:      pgood_i
    };

    spw_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_sync)
    );

    assign ctl_s = ctl_t'(ctl_sync);

    spw_rail_ctrl u_rails (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl_s),
        .sw_q (sw_q)
    );

    assign qual = reset_release_ok(ctl_s);

    spw_rst_timer #(
        .DELAY_CYC (RST_DELAY_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .qual (qual),
        .done (rel_done)
    );

    assign rail_sw_o    = sw_q;
    assign rail_dis_o   = ~sw_q;
    // Release waits for the timer; a failing condition pulls reset low at once
    assign card_rst_n_o = qual && rel_done;
    assign refclk_en_o  = refclk_ok(ctl_s);

endmodule

// File: rtl/slot_pwr_seq_chk.sv
module slot_pwr_seq_chk
    import slot_pwr_pkg::*;
#(
    parameter int DELAY_CYC = 600000
) (
    input logic       clk,
    input logic       rst,
    input ctl_t       ctl,
    input logic [2:0] sw,
    input logic [2:0] dis,
    input logic       rst_n,
    input logic       refclk
);

    localparam int CW = $clog2(DELAY_CYC + 2);

    logic          cond;
    logic          present;
    logic [CW-1:0] held;

    assign cond    = (ctl.pgood == 3'b111) && (ctl.pcie_det_n == 1'b0) && ctl.host_go && ctl.en;
    assign present = (ctl.pcie_det_n == 1'b0) || (ctl.usb_det_n == 1'b0);

    // Cycles the synchronized condition has held without a break
    always_ff @(posedge clk) begin
        if (rst || !cond)            held <= '0;
        else if (held != {CW{1'b1}}) held <= held + 1'b1;
    end

    AST_ABSENT_ALL_OFF: assert property (@(posedge clk) disable iff (rst) !present |=> sw == 3'b000); // R1
    AST_STANDBY_MAIN_OFF: assert property (@(posedge clk) disable iff (rst) !ctl.sys_on |=> sw[2:1] == 2'b00); // R3
    AST_DISABLED_DRAINS: assert property (@(posedge clk) disable iff (rst) !ctl.en |=> (sw == 3'b000) && (dis == 3'b111)); // R4
    AST_DIS_OPPOSES_SW: assert property (@(posedge clk) disable iff (rst) (sw & dis) == 3'b000 && (sw | dis) == 3'b111); // R5
    AST_HOT_OFF: assert property (@(posedge clk) disable iff (rst) ctl.hot |=> sw == 3'b000); // R6
    AST_UVLO_AUX_OFF: assert property (@(posedge clk) disable iff (rst) ctl.uvlo[RAIL_AUX] |=> !sw[RAIL_AUX]); // R7
    AST_RELEASE_WAIT: assert property (@(posedge clk) disable iff (rst) rst_n |-> held >= CW'(DELAY_CYC)); // R8 R10
    AST_RESET_DROPS: assert property (@(posedge clk) disable iff (rst) !cond |-> !rst_n); // R9
    AST_REFCLK_WITH_RST: assert property (@(posedge clk) disable iff (rst) rst_n |-> refclk); // R11
    AST_USB_ONLY_QUIET: assert property (@(posedge clk) disable iff (rst) ctl.pcie_det_n |-> !rst_n && !refclk); // R12

endmodule

bind slot_pwr_seq slot_pwr_seq_chk #(
    .DELAY_CYC (RST_DELAY_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl_s),
    .sw     (rail_sw_o),
    .dis    (rail_dis_o),
    .rst_n  (card_rst_n_o),
    .refclk (refclk_en_o)
);

// File: tb/slot_pwr_seq_tb_top.sv
module slot_pwr_seq_tb_top;

    localparam int DLY = 16;
    localparam int REL = DLY + 2;

    typedef struct {
        logic [2:0] sw;
        logic [2:0] dis;
        logic       rst_n;
        logic       refclk;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, sys = 1'b0, pcie_n = 1'b1, usb_n = 1'b1, host = 1'b0, hot = 1'b0;
    logic [2:0] pg = 3'b000, uv = 3'b000;
    logic [2:0] sw_o, dis_o;
    logic       rst_n_o, refclk_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   age      = 0;
    bit   all_done = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    slot_pwr_seq #(.RST_DELAY_CYC(DLY)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en),
        .sys_active_i (sys),
        .pcie_det_n_i (pcie_n),
        .usb_det_n_i  (usb_n),
        .host_rst_n_i (host),
        .pgood_i      (pg),
        .uvlo_i       (uv),
        .hot_i        (hot),
        .rail_sw_o    (sw_o),
        .rail_dis_o   (dis_o),
        .card_rst_n_o (rst_n_o),
        .refclk_en_o  (refclk_o)
    );

    // Expected rails written straight from R1..R7
    function automatic logic [2:0] model_rails();
        logic base;
        logic [2:0] r;
        base = en && !hot && (!pcie_n || !usb_n);
        r[0] = base && !uv[0];
        r[1] = base && sys && !uv[1];
        r[2] = base && sys && !uv[2];
        return r;
    endfunction

    // Driver: wait n rising edges after the stimulus, then queue the expectation
    task automatic step(int n, string tag);
        logic q;
        exp_t e;
        q = (pg == 3'b111) && !pcie_n && host && en;
        if (!q) age = 0;
        repeat (n) @(posedge clk);
        if (q) age += n;
        e.sw     = model_rails();
        e.dis    = ~e.sw;
        e.rst_n  = q && (age >= REL);
        e.refclk = en && !pcie_n && (pg == 3'b111);
        e.tag    = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (sw_o !== e.sw || dis_o !== e.dis || rst_n_o !== e.rst_n || refclk_o !== e.refclk) begin
                    n_fail++;
                    $display("FAIL %s: actual sw=%b dis=%b rst_n=%b refclk=%b expected sw=%b dis=%b rst_n=%b refclk=%b",
                             e.tag, sw_o, dis_o, rst_n_o, refclk_o, e.sw, e.dis, e.rst_n, e.refclk);
                end
            end
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        step(3, "R4 reset state");

        @(negedge clk); en = 1'b1; sys = 1'b1;
        step(4, "R1 no card active");
        @(negedge clk); sys = 1'b0;
        step(3, "R1 no card standby");

        @(negedge clk); sys = 1'b1; usb_n = 1'b0;
        step(3, "R1 R2 usb card active");
        @(negedge clk); pg = 3'b111; host = 1'b1;
        step(REL + 5, "R12 usb only no reset no clock");
        @(negedge clk); sys = 1'b0;
        step(3, "R3 usb card standby");
        @(negedge clk); sys = 1'b1;
        step(3, "R3 back to active");

        @(negedge clk); usb_n = 1'b1; pcie_n = 1'b0;
        step(REL - 1, "R8 R11 one edge before release");
        step(1, "R8 release edge");

        @(negedge clk); host = 1'b0;
        step(2, "R9 host request drops");
        @(negedge clk); host = 1'b1;
        step(REL, "R8 second release");

        @(negedge clk); pg = 3'b011;
        step(2, "R9 R11 power-good lost");
        @(negedge clk); pg = 3'b111;
        step(10, "R10 partial count");
        @(negedge clk); pg = 3'b101;
        step(3, "R10 interrupt");
        @(negedge clk); pg = 3'b111;
        step(REL - 1, "R10 restarted count");
        step(1, "R10 release after restart");

        @(negedge clk); hot = 1'b1;
        step(3, "R6 over-temp");
        @(negedge clk); hot = 1'b0;
        step(3, "R6 cleared");

        @(negedge clk); uv = 3'b010;
        step(3, "R7 main 3.3 undervoltage");
        @(negedge clk); uv = 3'b001;
        step(3, "R7 aux undervoltage");
        @(negedge clk); uv = 3'b100;
        step(3, "R7 main 1.5 undervoltage");
        @(negedge clk); uv = 3'b000;
        step(3, "R7 cleared");

        @(negedge clk); sys = 1'b0;
        step(3, "R3 pcie card standby");
        @(negedge clk); sys = 1'b1;
        step(3, "R3 pcie card active");

        @(negedge clk); en = 1'b0;
        step(3, "R4 R5 disabled drains");
        @(negedge clk); en = 1'b1; pcie_n = 1'b1;
        step(3, "R1 card removed");

        wait (sb_q.size() == 0);
        @(negedge clk);
        all_done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!all_done) begin
            n_fail++;
            $display("FAIL watchdog R1: actual=timeout expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule